// File: doc/BRIEF.md
# Effective Address Generator

This unit computes the effective address for one instruction of a small 8-bit processor. A request carries an addressing-mode code and the operand bytes of the instruction. It also carries the X and Y index registers, the program counter and the status flags. The unit returns a 16-bit address, a code that says what kind of result it is, and a one-cycle valid strobe. Modes that need no memory access finish one cycle after the request. The three indirect modes read a little-endian 16-bit pointer through a byte-wide read port, one byte per cycle, before they finish.

For branches, the unit sign-extends the offset byte and adds it to the program counter. It also reports whether the branch is taken, using a selected flag and the value that flag must have. The decoder that supplies the mode and the logic that fetches the operand data sit outside this block. The decoder must hold the request inputs steady only during the cycle in which `start` is accepted.

Top module: `ea_unit`

## Requirements
- R1: After reset, `ea_valid`, `mem_rd` and `busy` are all 0.
- R2: Mode code 3 (zero page) gives `ea = {0x00, opnd_lo}` with kind 0 (memory address).
- R3: Mode codes 4 and 5 (zero page indexed by X and by Y) give `ea = {0x00, (opnd_lo + index) mod 256}`, so the sum wraps inside page zero.
- R4: Mode codes 6, 7 and 8 (absolute, absolute+X, absolute+Y) give `ea = ({opnd_hi, opnd_lo} + index) mod 65536`, where the index is 0 for code 6. For example, base 0xF453 with X=3 gives 0xF456.
- R5: Mode code 9 (index, then pointer) reads the low pointer byte at `{0x00, opnd_lo+X}` and the high byte at the next zero-page location, with both addresses wrapping mod 256. The result is `ea = {high, low}`.
- R6: Mode code 10 (pointer, then index) reads the low byte at `{0x00, opnd_lo}` and the high byte at `{0x00, opnd_lo+1 mod 256}`. The result is `ea = ({high, low} + Y) mod 65536`.
- R7: Mode code 11 (absolute indirect, used by jumps) reads the low byte at `{opnd_hi, opnd_lo}` and the high byte at that address plus 1 mod 65536. The carry propagates into the high byte in the default configuration. The result is `ea = {high, low}`.
- R8: A direct mode raises `ea_valid` in the cycle after `start` is accepted. A pointer mode asserts `mem_rd` in each of the two cycles after acceptance, and raises `ea_valid` in the cycle after the second read. `ea_valid` is a one-cycle pulse.
- R9: Mode code 12 (relative) gives `ea = (pc + sign_extend(opnd_lo)) mod 65536`. For example, 0x7F adds 127 and 0xF9 adds -7.
- R10: `flags` bit 0 is C, bit 1 is Z, bit 2 is N and bit 3 is V. For mode 12, `br_taken = (flags[cond_sel] == cond_val)`. For every other mode, `br_taken` is 0.
- R11: `ea_kind` uses these codes: 0 for a memory address, 1 for immediate (mode 2, with `ea = pc`), 2 for accumulator (mode 1, with `ea = 0`), and 3 for no operand (mode 0 and the unused codes 13 to 15, with `ea = 0`).
- R12: A `start` asserted while `busy` is 1 is ignored. It does not change the result in progress and does not add a valid strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, accepted when `busy` is 0 |
| mode | input | 4 | Addressing-mode code (R2 to R11) |
| opnd_lo | input | 8 | First operand byte |
| opnd_hi | input | 8 | Second operand byte |
| idx_x | input | 8 | X index register |
| idx_y | input | 8 | Y index register |
| pc | input | 16 | Current program counter |
| flags | input | 4 | Status flags {V,N,Z,C} |
| cond_sel | input | 2 | Flag selected for the branch test |
| cond_val | input | 1 | Value the selected flag must have for the branch to be taken |
| mem_rdata | input | 8 | Read data, valid in the same cycle as `mem_rd` |
| mem_addr | output | 16 | Pointer-byte read address |
| mem_rd | output | 1 | Pointer-byte read strobe |
| busy | output | 1 | A pointer fetch is in progress |
| ea | output | 16 | Effective address |
| ea_kind | output | 2 | Result kind (R11) |
| ea_valid | output | 1 | Result strobe |
| br_taken | output | 1 | Branch decision (R10) |

## Verification
The bench builds the unit with its defaults: 8-bit data, 16-bit addresses, and the pointer high byte carrying across a page. This small width makes every zero-page operand and every one of the 256 relative offsets cheap to sweep. It also makes every combination of the four flags with each condition select and required value cheap to sweep. A bench-side memory whose byte is a simple function of its address makes every pointer value predictable. With that memory, the bench reaches the wrap at the top of page zero and the page crossing of the jump pointer. It also reaches the wrap of the full 16-bit space for the indexed and relative sums.

// File: rtl/ea_pkg.sv
package ea_pkg;
   typedef enum logic [3:0] {
      AM_IMPL = 4'd0,
      AM_ACC  = 4'd1,
      AM_IMM  = 4'd2,
      AM_ZP   = 4'd3,
      AM_ZPX  = 4'd4,
      AM_ZPY  = 4'd5,
      AM_ABS  = 4'd6,
      AM_ABSX = 4'd7,
      AM_ABSY = 4'd8,
      AM_INDX = 4'd9,
      AM_INDY = 4'd10,
      AM_IND  = 4'd11,
      AM_REL  = 4'd12
   } am_e;

   typedef enum logic [1:0] {
      EK_MEM  = 2'd0,
      EK_IMM  = 2'd1,
      EK_ACC  = 2'd2,
      EK_NONE = 2'd3
   } ek_e;

   localparam int FLAG_W = 4;
   localparam int SEL_W  = $clog2(FLAG_W);
endpackage

// File: rtl/ea_branch_eval.sv
module ea_branch_eval
   import ea_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 16
) (
   input  logic [ADDR_W-1:0] pc,
   input  logic [DATA_W-1:0] ofs,
   input  logic [FLAG_W-1:0] flags,
   input  logic [SEL_W-1:0]  sel,
   input  logic              want,
   output logic [ADDR_W-1:0] target,
   output logic              taken
);
   localparam int PAD = ADDR_W - DATA_W;

   logic [ADDR_W-1:0] ofs_ext;

   // sign extension of the branch displacement
   assign ofs_ext = {{PAD{ofs[DATA_W-1]}}, ofs};
   assign target  = pc + ofs_ext;
   assign taken   = (flags[sel] == want);
endmodule

// File: rtl/ea_direct_calc.sv
module ea_direct_calc
   import ea_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 16
) (
   input  am_e               am,
   input  logic [DATA_W-1:0] lo,
   input  logic [DATA_W-1:0] hi,
   input  logic [DATA_W-1:0] ix,
   input  logic [DATA_W-1:0] iy,
   input  logic [ADDR_W-1:0] pc,
   input  logic [FLAG_W-1:0] flags,
   input  logic [SEL_W-1:0]  sel,
   input  logic              want,
   output logic [ADDR_W-1:0] ea,
   output ek_e               kind,
   output logic              taken
);
   localparam int PAD = ADDR_W - DATA_W;

   logic [DATA_W-1:0] zp_x, zp_y;
   logic [ADDR_W-1:0] base, rel_tgt;
   logic              rel_take;

   assign zp_x = lo + ix;
   assign zp_y = lo + iy;
   assign base = {hi, lo};

   ea_branch_eval #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_br (
      .pc     (pc),
      .ofs    (lo),
      .flags  (flags),
      .sel    (sel),
      .want   (want),
      .target (rel_tgt),
      .taken  (rel_take)
   );

   always_comb begin
      ea    = '0;
      kind  = EK_MEM;
      taken = 1'b0;
      case (am)
         AM_ZP:   ea = {{PAD{1'b0}}, lo};
         AM_ZPX:  ea = {{PAD{1'b0}}, zp_x};
         AM_ZPY:  ea = {{PAD{1'b0}}, zp_y};
         AM_ABS:  ea = base;
         AM_ABSX: ea = base + {{PAD{1'b0}}, ix};
         AM_ABSY: ea = base + {{PAD{1'b0}}, iy};
         AM_IMM:  begin ea = pc; kind = EK_IMM; end
         AM_ACC:  kind = EK_ACC;
         AM_REL:  begin ea = rel_tgt; taken = rel_take; end
         default: kind = EK_NONE;
      endcase
   end
endmodule

// File: rtl/ea_ptr_seq.sv
module ea_ptr_seq #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch,
   input  logic [ADDR_W-1:0] base_addr,
   input  logic              wrap_page,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              busy,
   output logic              done,
   output logic [ADDR_W-1:0] word
);
   typedef enum logic [1:0] {S_IDLE, S_LO, S_HI} st_e;

   st_e               st;
   logic [ADDR_W-1:0] ptr_q, ptr_next;
   logic [DATA_W-1:0] lo_q, lo_inc;
   logic              wrap_q;

   assign lo_inc   = ptr_q[DATA_W-1:0] + 1'b1;
   assign ptr_next = wrap_q ? {ptr_q[ADDR_W-1:DATA_W], lo_inc} : ptr_q + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= S_IDLE;
         ptr_q  <= '0;
         lo_q   <= '0;
         wrap_q <= 1'b0;
      end else begin
         case (st)
            S_IDLE: if (launch) begin
               st     <= S_LO;
               ptr_q  <= base_addr;
               wrap_q <= wrap_page;
            end
            S_LO: begin
               lo_q <= mem_rdata;
               st   <= S_HI;
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   assign mem_rd   = (st != S_IDLE);
   assign busy     = (st != S_IDLE);
   assign done     = (st == S_HI);
   assign mem_addr = (st == S_HI) ? ptr_next : ptr_q;
   assign word     = {mem_rdata, lo_q};
endmodule

// File: rtl/ea_unit.sv
module ea_unit
   import ea_pkg::*;
#(
   parameter int DATA_W        = 8,
   parameter int ADDR_W        = 16,
   parameter bit IND_PAGE_WRAP = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [3:0]        mode,
   input  logic [DATA_W-1:0] opnd_lo,
   input  logic [DATA_W-1:0] opnd_hi,
   input  logic [DATA_W-1:0] idx_x,
   input  logic [DATA_W-1:0] idx_y,
   input  logic [ADDR_W-1:0] pc,
   input  logic [3:0]        flags,
   input  logic [1:0]        cond_sel,
   input  logic              cond_val,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              busy,
   output logic [ADDR_W-1:0] ea,
   output logic [1:0]        ea_kind,
   output logic              ea_valid,
   output logic              br_taken
);
   localparam int PAD = ADDR_W - DATA_W;

   generate
      if (ADDR_W != 2 * DATA_W) begin : g_bad_width
         $error("ea_unit: ADDR_W must be twice DATA_W");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("ea_unit: DATA_W too small");
      end
   endgenerate

   am_e               am;
   logic              is_ptr, accept, launch;
   logic [ADDR_W-1:0] d_ea, base_addr, seq_word;
   ek_e               d_kind;
   logic              d_taken, wrap_page, ind_wrap, seq_busy, seq_done;
   logic [DATA_W-1:0] zp_ix;

   logic [ADDR_W-1:0] ea_q;
   ek_e               kind_q;
   logic              valid_q, taken_q, indy_q;
   logic [DATA_W-1:0] y_q;

   assign am     = am_e'(mode);
   assign is_ptr = (am == AM_INDX) || (am == AM_INDY) || (am == AM_IND);
   assign accept = start && !seq_busy;
   assign launch = accept && is_ptr;
   assign zp_ix  = opnd_lo + idx_x;

   generate
      if (IND_PAGE_WRAP) begin : g_ind_wrap
         assign ind_wrap = 1'b1;
      end else begin : g_ind_carry
         assign ind_wrap = 1'b0;
      end
   endgenerate

   always_comb begin
      case (am)
         AM_INDX: begin base_addr = {{PAD{1'b0}}, zp_ix};   wrap_page = 1'b1;     end
         AM_INDY: begin base_addr = {{PAD{1'b0}}, opnd_lo}; wrap_page = 1'b1;     end
         default: begin base_addr = {opnd_hi, opnd_lo};     wrap_page = ind_wrap; end
      endcase
   end

   ea_direct_calc #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dir (
      .am    (am),
      .lo    (opnd_lo),
      .hi    (opnd_hi),
      .ix    (idx_x),
      .iy    (idx_y),
      .pc    (pc),
      .flags (flags),
      .sel   (cond_sel),
      .want  (cond_val),
      .ea    (d_ea),
      .kind  (d_kind),
      .taken (d_taken)
   );

   ea_ptr_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .launch    (launch),
      .base_addr (base_addr),
      .wrap_page (wrap_page),
      .mem_rdata (mem_rdata),
      .mem_addr  (mem_addr),
      .mem_rd    (mem_rd),
      .busy      (seq_busy),
      .done      (seq_done),
      .word      (seq_word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ea_q    <= '0;
         kind_q  <= EK_NONE;
         valid_q <= 1'b0;
         taken_q <= 1'b0;
         indy_q  <= 1'b0;
         y_q     <= '0;
      end else begin
         valid_q <= 1'b0;
         if (seq_done) begin
            valid_q <= 1'b1;
            ea_q    <= indy_q ? seq_word + {{PAD{1'b0}}, y_q} : seq_word;
            kind_q  <= EK_MEM;
            taken_q <= 1'b0;
         end else if (accept && !is_ptr) begin
            valid_q <= 1'b1;
            ea_q    <= d_ea;
            kind_q  <= d_kind;
            taken_q <= d_taken;
         end
         if (launch) begin
            y_q    <= idx_y;
            indy_q <= (am == AM_INDY);
         end
      end
   end

   assign busy     = seq_busy;
   assign ea       = ea_q;
   assign ea_kind  = kind_q;
   assign ea_valid = valid_q;
   assign br_taken = taken_q;
endmodule

// File: rtl/ea_unit_chk.sv
module ea_unit_chk
   import ea_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [3:0]        mode,
   input logic [ADDR_W-1:0] pc,
   input logic              busy,
   input logic              mem_rd,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [ADDR_W-1:0] ea,
   input logic [1:0]        ea_kind,
   input logic              ea_valid
);
   logic take, ptr_mode;
   assign take     = start && !busy;
   assign ptr_mode = (mode == AM_INDX) || (mode == AM_INDY) || (mode == AM_IND);

   AST_DIRECT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      take && !ptr_mode |=> ea_valid); // R8
   AST_PTR_FIRST_READ: assert property (@(posedge clk) disable iff (!rst_n)
      take && ptr_mode |=> mem_rd && !ea_valid); // R8
   AST_READ_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd && !$past(mem_rd) |=> mem_rd); // R8
   AST_READ_THEN_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd && $past(mem_rd) |=> !mem_rd && ea_valid && ea_kind == 2'd0); // R8
   AST_VALID_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      ea_valid |-> $past(take) || $past(mem_rd)); // R12
   AST_HI_BYTE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd && $past(mem_rd) |-> mem_addr[DATA_W-1:0] == DATA_W'($past(mem_addr[DATA_W-1:0]) + 1'b1)); // R5
   AST_ZP_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      take && mode == AM_ZP |=> ea[ADDR_W-1:DATA_W] == '0); // R2
   AST_IMM_IS_PC: assert property (@(posedge clk) disable iff (!rst_n)
      take && mode == AM_IMM |=> ea_kind == 2'd1 && ea == $past(pc)); // R11
endmodule

bind ea_unit ea_unit_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .mode     (mode),
   .pc       (pc),
   .busy     (busy),
   .mem_rd   (mem_rd),
   .mem_addr (mem_addr),
   .ea       (ea),
   .ea_kind  (ea_kind),
   .ea_valid (ea_valid)
);

// File: tb/sim_ea_unit.sv
module sim_ea_unit;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [3:0]  mode = '0;
   logic [7:0]  opnd_lo = '0, opnd_hi = '0, idx_x = '0, idx_y = '0;
   logic [15:0] pc = '0;
   logic [3:0]  flags = '0;
   logic [1:0]  cond_sel = '0;
   logic        cond_val = 1'b0;
   logic [7:0]  mem_rdata;
   logic [15:0] mem_addr, ea;
   logic        mem_rd, busy, ea_valid, br_taken;
   logic [1:0]  ea_kind;

   int checks = 0;
   int failures = 0;

   always #(CLK_P/2) clk = ~clk;

   ea_unit u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
      .opnd_lo(opnd_lo), .opnd_hi(opnd_hi), .idx_x(idx_x), .idx_y(idx_y),
      .pc(pc), .flags(flags), .cond_sel(cond_sel), .cond_val(cond_val),
      .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_rd(mem_rd),
      .busy(busy), .ea(ea), .ea_kind(ea_kind), .ea_valid(ea_valid),
      .br_taken(br_taken)
   );

   function automatic logic [7:0] memf(input logic [15:0] a);
      return (a[7:0] * 8'd7) ^ a[15:8] ^ 8'h3C;
   endfunction

   always_comb mem_rdata = memf(mem_addr);

   task automatic chk(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // called at a falling edge; returns at a falling edge
   task automatic run(input logic [3:0] m, input logic [7:0] lo, input logic [7:0] hi,
                      input logic [7:0] x, input logic [7:0] y, input logic [15:0] p,
                      input logic [3:0] fl, input logic [1:0] cs, input logic cv,
                      input logic [15:0] exp_ea, input logic [1:0] exp_kind,
                      input logic exp_taken, input logic is_ptr,
                      input logic [15:0] a0, input logic [15:0] a1, input string tag);
      mode = m; opnd_lo = lo; opnd_hi = hi; idx_x = x; idx_y = y; pc = p;
      flags = fl; cond_sel = cs; cond_val = cv; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (is_ptr) begin
         chk(mem_rd && !ea_valid, {tag, " R8 first read"}, {15'd0, mem_rd}, 16'd1);
         chk(mem_addr == a0, {tag, " low pointer addr"}, mem_addr, a0);
         @(negedge clk);
         chk(mem_rd && !ea_valid, {tag, " R8 second read"}, {15'd0, mem_rd}, 16'd1);
         chk(mem_addr == a1, {tag, " high pointer addr"}, mem_addr, a1);
         @(negedge clk);
         chk(!mem_rd, {tag, " R8 reads end"}, {15'd0, mem_rd}, 16'd0);
      end
      chk(ea_valid, {tag, " R8 valid"}, {15'd0, ea_valid}, 16'd1);
      chk(ea == exp_ea, tag, ea, exp_ea);
      chk(ea_kind == exp_kind, {tag, " R11 kind"}, {14'd0, ea_kind}, {14'd0, exp_kind});
      chk(br_taken == exp_taken, {tag, " R10 taken"}, {15'd0, br_taken}, {15'd0, exp_taken});
      @(negedge clk);
      chk(!ea_valid, {tag, " R8 single pulse"}, {15'd0, ea_valid}, 16'd0);
   endtask

   initial begin
      #(CLK_P * 100000);
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [7:0]  xs [8] = '{8'h00, 8'h01, 8'h03, 8'h7F, 8'h80, 8'hC0, 8'hFE, 8'hFF};
      logic [15:0] bases [6] = '{16'hF453, 16'h0000, 16'h00FF, 16'h12FF, 16'hFFFF, 16'h8001};

      repeat (3) @(negedge clk);
      chk(!ea_valid && !mem_rd && !busy, "R1 reset state", {13'd0, ea_valid, mem_rd, busy}, 16'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!ea_valid && !mem_rd && !busy, "R1 after release", {13'd0, ea_valid, mem_rd, busy}, 16'd0);

      // R2 all zero-page operands; flags chosen so a branch test would match (R10)
      for (int i = 0; i < 256; i++) begin
         logic [7:0] b;
         b = 8'(i);
         run(4'd3, b, 8'hA5, 8'h11, 8'h22, 16'h4000, 4'hF, 2'd0, 1'b1,
             {8'h00, b}, 2'd0, 1'b0, 1'b0, 16'h0, 16'h0, "R2 zp");
      end

      // R3 zero page indexed
      for (int i = 0; i < 256; i += 17) begin
         foreach (xs[k]) begin
            logic [7:0] b, s;
            b = 8'(i);
            s = b + xs[k];
            run(4'd4, b, 8'h77, xs[k], 8'h00, 16'h0, 4'h0, 2'd0, 1'b0,
                {8'h00, s}, 2'd0, 1'b0, 1'b0, 16'h0, 16'h0, "R3 zpx");
            run(4'd5, b, 8'h77, 8'h00, xs[k], 16'h0, 4'h0, 2'd0, 1'b0,
                {8'h00, s}, 2'd0, 1'b0, 1'b0, 16'h0, 16'h0, "R3 zpy");
         end
      end

      // R4 absolute and absolute indexed
      foreach (bases[j]) begin
         run(4'd6, bases[j][7:0], bases[j][15:8], 8'h44, 8'h55, 16'h0, 4'h0, 2'd0, 1'b0,
             bases[j], 2'd0, 1'b0, 1'b0, 16'h0, 16'h0, "R4 abs");
         foreach (xs[k]) begin
            logic [15:0] s;
            s = bases[j] + {8'h00, xs[k]};
            run(4'd7, bases[j][7:0], bases[j][15:8], xs[k], 8'h00, 16'h0, 4'h0, 2'd0, 1'b0,
                s, 2'd0, 1'b0, 1'b0, 16'h0, 16'h0, "R4 absx");
            run(4'd8, bases[j][7:0], bases[j][15:8], 8'h00, xs[k], 16'h0, 4'h0, 2'd0, 1'b0,
                s, 2'd0, 1'b0, 1'b0, 16'h0, 16'h0, "R4 absy");
         end
      end

      // R5 / R6 indirect through page zero, wrap at 0xFF
      for (int i = 0; i < 256; i += 5) begin
         foreach (xs[k]) begin
            logic [7:0]  b, p0, p1, q1;
            logic [15:0] w;
            b  = 8'(i);
            p0 = b + xs[k];
            p1 = p0 + 8'd1;
            w  = {memf({8'h00, p1}), memf({8'h00, p0})};
            run(4'd9, b, 8'h99, xs[k], 8'h33, 16'h0, 4'h0, 2'd0, 1'b0,
                w, 2'd0, 1'b0, 1'b1, {8'h00, p0}, {8'h00, p1}, "R5 indx");
            q1 = b + 8'd1;
            w  = {memf({8'h00, q1}), memf({8'h00, b})} + {8'h00, xs[k]};
            run(4'd10, b, 8'h99, 8'h33, xs[k], 16'h0, 4'h0, 2'd0, 1'b0,
                w, 2'd0, 1'b0, 1'b1, {8'h00, b}, {8'h00, q1}, "R6 indy");
         end
      end
      run(4'd9, 8'hB4, 8'h00, 8'h06, 8'h00, 16'h0, 4'h0, 2'd0, 1'b0,
          {memf(16'h00BB), memf(16'h00BA)}, 2'd0, 1'b0, 1'b1, 16'h00BA, 16'h00BB, "R5 indx b4");

      // R7 absolute indirect with carry across a page
      foreach (bases[j]) begin
         logic [15:0] n;
         n = bases[j] + 16'd1;
         run(4'd11, bases[j][7:0], bases[j][15:8], 8'h12, 8'h34, 16'h0, 4'h0, 2'd0, 1'b0,
             {memf(n), memf(bases[j])}, 2'd0, 1'b0, 1'b1, bases[j], n, "R7 ind");
      end

      // R9 all branch offsets at two program counters
      for (int i = 0; i < 256; i++) begin
         logic [7:0] b;
         b = 8'(i);
         run(4'd12, b, 8'h00, 8'h00, 8'h00, 16'h8000, 4'b0001, 2'd0, 1'b1,
             16'h8000 + {{8{b[7]}}, b}, 2'd0, 1'b1, 1'b0, 16'h0, 16'h0, "R9 rel");
         run(4'd12, b, 8'h00, 8'h00, 8'h00, 16'h0005, 4'b0001, 2'd0, 1'b0,
             16'h0005 + {{8{b[7]}}, b}, 2'd0, 1'b0, 1'b0, 16'h0, 16'h0, "R9 rel low");
      end

      // R10 every flag pattern, selector and wanted value
      for (int f = 0; f < 16; f++) begin
         for (int s = 0; s < 4; s++) begin
            for (int v = 0; v < 2; v++) begin
               logic [3:0] fl;
               fl = 4'(f);
               run(4'd12, 8'hF9, 8'h00, 8'h00, 8'h00, 16'h1000, fl, 2'(s), 1'(v),
                   16'h0FF9, 2'd0, fl[s] == 1'(v), 1'b0, 16'h0, 16'h0, "R10 cond");
            end
         end
      end

      // R11 non-address kinds
      run(4'd2, 8'h12, 8'h34, 8'h00, 8'h00, 16'hBEEF, 4'hF, 2'd1, 1'b1,
          16'hBEEF, 2'd1, 1'b0, 1'b0, 16'h0, 16'h0, "R11 imm");
      run(4'd1, 8'h12, 8'h34, 8'h00, 8'h00, 16'hBEEF, 4'h0, 2'd0, 1'b0,
          16'h0000, 2'd2, 1'b0, 1'b0, 16'h0, 16'h0, "R11 acc");
      for (int c = 13; c < 17; c++) begin
         logic [3:0] m;
         m = (c == 16) ? 4'd0 : 4'(c);
         run(m, 8'h12, 8'h34, 8'h56, 8'h78, 16'hBEEF, 4'h0, 2'd0, 1'b0,
             16'h0000, 2'd3, 1'b0, 1'b0, 16'h0, 16'h0, "R11 none");
      end

      // R12 a start during the pointer fetch is ignored
      begin
         logic [15:0] w;
         w = {memf(16'h00A1), memf(16'h00A0)};
         mode = 4'd10; opnd_lo = 8'hA0; idx_y = 8'h00; start = 1'b1;
         @(negedge clk);
         mode = 4'd3; opnd_lo = 8'h55; idx_y = 8'hFF;  // busy: must be ignored
         @(negedge clk);
         start = 1'b0;
         chk(mem_addr == 16'h00A1, "R12 fetch continues", mem_addr, 16'h00A1);
         @(negedge clk);
         chk(ea_valid && ea == w, "R12 result unchanged", ea, w);
         @(negedge clk);
         chk(!ea_valid, "R12 no extra strobe", {15'd0, ea_valid}, 16'd0);
         @(negedge clk);
         chk(!ea_valid && !busy, "R12 idle afterwards", {14'd0, ea_valid, busy}, 16'd0);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule